// File: doc/BRIEF.md
# Transmit Primitive Stream Conditioner

This block sits on the transmit side of a serial storage link. It is placed after the link-layer transmit controller and before the 8b/10b encoder. It accepts a stream of 32-bit dwords over a valid/ready handshake. Each dword is tagged as a primitive or as data. Every clock cycle it emits exactly one dword, together with a flag that marks byte 0 as a control (K) character. Dwords go out low byte first, so byte 0 is bits 7:0.

The block has two jobs. The first is to keep the receiver's symbol alignment alive. It does this by emitting a pair of ALIGN primitives at a fixed output cadence, and it stalls the upstream while the pair goes out. The second is to lower emissions during long runs of an identical primitive. In such a run the third occurrence is replaced by CONT, and later occurrences are replaced by pseudo-random filler dwords. A one-dword lookahead lets the final occurrence of every run go out as the real primitive, which keeps a trailing HOLD or HOLDA visible.

Top module: `tx_prim_conditioner`

## Requirements
- R1: After reset is released, the first two output dwords are ALIGN (0x7B4A4ABC) with out_k high.
- R2: An output cycle counter starts at 0 on the first cycle after reset and advances every cycle. When its value modulo ALIGN_PERIOD (default 128) is 0 or 1, the output is ALIGN with out_k high.
- R3: An ALIGN pair never replaces an upstream dword. The upstream is stalled with in_ready low, and every accepted dword is emitted in order. While a dword and its successor are both available outside an ALIGN slot, no ALIGN is emitted.
- R4: out_k is high only for primitives. A primitive's byte 0 is 0xBC for ALIGN and 0x7C for every other primitive. out_k is low for data dwords and for filler dwords, even when a data value equals a primitive's bit pattern.
- R5: Only these primitives are repeatable: SYNC 0xB5B5957C, R_RDY 0x4A4A957C, R_IP 0x5555B57C, R_OK 0x3535B57C, R_ERR 0x5656B57C, X_RDY 0x5757B57C, WTRM 0x5858B57C, HOLD 0xD5D5AA7C, HOLDA 0x9595AA7C. All other primitives (such as SOF 0x3737B57C and EOF 0xD5D5B57C) and all data dwords pass unchanged, whatever their repetition.
- R6: With suppress_en high, a run is a sequence of accepted dwords with identical value and primitive tag. In such a run of a repeatable primitive, occurrence 3 is emitted as CONT (0x9999AA7C, out_k high), and occurrences 4 and later are emitted as filler (out_k low).
- R7: The last occurrence of every run of a repeatable primitive is emitted as the real primitive. The last occurrence is the one whose next accepted dword differs from it. As a result, runs of three or fewer go out unchanged.
- R8: Filler comes from a 16-bit generator. The generator is set to 0xFFFF by reset and advances by 32 steps every clock cycle. In each step, the low state bit x is taken as filler bit i (i rising from 0 to 31); the state then shifts right by one and, if x is 1, is XORed with 0x8805.
- R9: ALIGN dwords inserted in the middle of a run do not break it. Occurrence counting continues after the pair, and filler resumes.
- R10: With suppress_en low, every accepted dword is emitted unchanged, and ALIGN insertion still follows R2.
- R11: When no accepted dword can be emitted, the output is ALIGN with out_k high. This covers the case where the held dword has no successor yet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (link up) |
| suppress_en | input | 1 | Enables CONT and filler substitution of repeated primitives |
| in_valid | input | 1 | Upstream dword available |
| in_ready | output | 1 | Upstream dword accepted this cycle when in_valid is high |
| in_dword | input | 32 | Upstream dword, byte 0 in bits 7:0 |
| in_is_prim | input | 1 | Upstream dword is a primitive |
| out_dword | output | 32 | Dword to the encoder |
| out_k | output | 1 | Byte 0 of out_dword is a K character |

## Verification
The assertions assume that the upstream tags as primitives only dwords whose byte 0 is 0x7C, that it never sends ALIGN or CONT itself, and that it keeps in_valid high except when its stream has ended. The stimulus respects all three. It builds each stream from the fixed primitive constants and from data dwords tagged as data. It presents the next dword continuously until the stream is exhausted, and only then drops in_valid. It changes suppress_en only while reset is asserted.

// File: rtl/tx_cond_pkg.sv
package tx_cond_pkg;

    localparam logic [31:0] PRIM_ALIGN = 32'h7B4A4ABC;
    localparam logic [31:0] PRIM_CONT  = 32'h9999AA7C;
    localparam logic [31:0] PRIM_SYNC  = 32'hB5B5957C;
    localparam logic [31:0] PRIM_RRDY  = 32'h4A4A957C;
    localparam logic [31:0] PRIM_RIP   = 32'h5555B57C;
    localparam logic [31:0] PRIM_ROK   = 32'h3535B57C;
    localparam logic [31:0] PRIM_RERR  = 32'h5656B57C;
    localparam logic [31:0] PRIM_XRDY  = 32'h5757B57C;
    localparam logic [31:0] PRIM_WTRM  = 32'h5858B57C;
    localparam logic [31:0] PRIM_HOLD  = 32'hD5D5AA7C;
    localparam logic [31:0] PRIM_HOLDA = 32'h9595AA7C;

    localparam logic [15:0] FILL_SEED = 16'hFFFF;
    localparam logic [15:0] FILL_TAPS = 16'h8805;
    localparam logic [2:0]  RUN_SAT   = 3'd4;

    typedef struct packed {
        logic [31:0] dw;
        logic        prim;
    } word_t;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_CONT = 2'd1,
        SEL_FILL = 2'd2
    } sel_e;

    function automatic logic is_repeatable(input word_t w);
        return w.prim && (w.dw inside {PRIM_SYNC, PRIM_RRDY, PRIM_RIP, PRIM_ROK,
                                       PRIM_RERR, PRIM_XRDY, PRIM_WTRM,
                                       PRIM_HOLD, PRIM_HOLDA});
    endfunction

    function automatic logic [15:0] fill_next(input logic [15:0] s);
        logic [15:0] t;
        t = s;
        for (int i = 0; i < 32; i++) begin
            t = t[0] ? ((t >> 1) ^ FILL_TAPS) : (t >> 1);
        end
        return t;
    endfunction

    function automatic logic [31:0] fill_bits(input logic [15:0] s);
        logic [15:0] t;
        logic [31:0] r;
        t = s;
        for (int i = 0; i < 32; i++) begin
            r[i] = t[0];
            t = t[0] ? ((t >> 1) ^ FILL_TAPS) : (t >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_align_pacer.sv
module tx_align_pacer #(
    parameter int PERIOD = 128
) (
    input  logic clk,
    input  logic rst,
    output logic slot
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (pos == LAST) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // Two consecutive positions at the start of each period carry ALIGN
    assign slot = (pos < CW'(2));

endmodule

// File: rtl/tx_filler_lfsr.sv
module tx_filler_lfsr
    import tx_cond_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] filler
);
    logic [15:0] state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FILL_SEED;
        end else begin
            state <= fill_next(state);
        end
    end

    assign filler = fill_bits(state);

endmodule

// File: rtl/tx_run_tracker.sv
module tx_run_tracker
    import tx_cond_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  logic  en,
    input  word_t cur,
    input  word_t nxt,
    output sel_e  sel
);
    word_t      last_q;
    logic       last_ok;
    logic [2:0] cnt_q;

    logic       cur_rep;
    logic       cont_run;
    logic       is_final;
    logic [2:0] occ;

    always_comb begin
        cur_rep  = en && is_repeatable(cur);
        cont_run = cur_rep && last_ok && (last_q == cur);
        if (!cont_run) begin
            occ = 3'd1;
        end else if (cnt_q >= RUN_SAT) begin
            occ = RUN_SAT;
        end else begin
            occ = cnt_q + 3'd1;
        end
        is_final = (nxt != cur);

        sel = SEL_PASS;
        if (cur_rep && !is_final) begin
            if (occ == 3'd3) begin
                sel = SEL_CONT;
            end else if (occ >= RUN_SAT) begin
                sel = SEL_FILL;
            end
        end
    end

    // Only emitted upstream dwords move the run state; ALIGN cycles leave it untouched
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= '0;
            last_ok <= 1'b0;
            cnt_q   <= '0;
        end else if (advance) begin
            last_q  <= cur;
            last_ok <= cur_rep;
            cnt_q   <= cur_rep ? occ : 3'd0;
        end
    end

endmodule

// File: rtl/tx_prim_conditioner.sv
module tx_prim_conditioner
    import tx_cond_pkg::*;
#(
    parameter int ALIGN_PERIOD = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        suppress_en,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_dword,
    input  logic        in_is_prim,
    output logic [31:0] out_dword,
    output logic        out_k
);
    word_t       hold_q;
    word_t       nxt;
    logic        hold_v;
    logic        align_slot;
    logic        emit;
    logic [31:0] filler;
    sel_e        sel;

    assign nxt = '{dw: in_dword, prim: in_is_prim};

    tx_align_pacer #(.PERIOD(ALIGN_PERIOD)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .slot (align_slot)
    );

    tx_filler_lfsr u_filler (
        .clk    (clk),
        .rst    (rst),
        .filler (filler)
    );

    tx_run_tracker u_runs (
        .clk     (clk),
        .rst     (rst),
        .advance (emit),
        .en      (suppress_en),
        .cur     (hold_q),
        .nxt     (nxt),
        .sel     (sel)
    );

    // The held dword leaves only when its successor is visible (lookahead)
    assign emit     = hold_v && in_valid && !align_slot;
    assign in_ready = emit || !hold_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            hold_v <= 1'b0;
        end else if (in_ready && in_valid) begin
            hold_q <= nxt;
            hold_v <= 1'b1;
        end
    end

    always_comb begin
        if (!emit) begin
            out_dword = PRIM_ALIGN;
            out_k     = 1'b1;
        end else begin
            unique case (sel)
                SEL_CONT: begin
                    out_dword = PRIM_CONT;
                    out_k     = 1'b1;
                end
                SEL_FILL: begin
                    out_dword = filler;
                    out_k     = 1'b0;
                end
                default: begin
                    out_dword = hold_q.dw;
                    out_k     = hold_q.prim;
                end
            endcase
        end
    end

endmodule

// File: rtl/tx_prim_conditioner_chk.sv
module tx_prim_conditioner_chk
    import tx_cond_pkg::*;
#(
    parameter int ALIGN_PERIOD = 128
) (
    input logic        clk,
    input logic        rst,
    input logic        suppress_en,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_dword,
    input logic        in_is_prim,
    input logic [31:0] out_dword,
    input logic        out_k
);
    logic        out_align;
    logic        out_cont;
    logic [15:0] gap;

    assign out_align = out_k && (out_dword == PRIM_ALIGN);
    assign out_cont  = out_k && (out_dword == PRIM_CONT);

    always_ff @(posedge clk) begin
        if (rst || out_align) begin
            gap <= '0;
        end else begin
            gap <= gap + 16'd1;
        end
    end

    // R1: first output after reset is ALIGN
    a_r1_align_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> out_align);

    // R2: no stretch of non-ALIGN outputs longer than the period less the pair
    a_r2_align_spacing: assert property (@(posedge clk) disable iff (rst)
        !out_align |-> (gap < 16'(ALIGN_PERIOD - 2)));

    // R4: a K-flagged byte 0 is one of the two control characters
    a_r4_k_byte: assert property (@(posedge clk) disable iff (rst)
        out_k |-> (out_dword[7:0] == 8'hBC || out_dword[7:0] == 8'h7C));

    // R6: CONT is followed by filler, ALIGN or the run's real primitive
    a_r6_after_cont: assert property (@(posedge clk) disable iff (rst)
        out_cont |=> (!out_k || out_align ||
                      is_repeatable('{dw: out_dword, prim: out_k})));

    // R10: no CONT appears while suppression is off
    a_r10_bypass_no_cont: assert property (@(posedge clk) disable iff (rst)
        !suppress_en |-> !out_cont);

endmodule

bind tx_prim_conditioner tx_prim_conditioner_chk #(.ALIGN_PERIOD(ALIGN_PERIOD)) u_chk (.*);

// File: tb/tx_prim_conditioner_bench.sv
module tx_prim_conditioner_bench;
    localparam int P = 32;

    localparam logic [31:0] C_ALIGN = 32'h7B4A4ABC;
    localparam logic [31:0] C_CONT  = 32'h9999AA7C;
    localparam logic [31:0] C_SYNC  = 32'hB5B5957C;
    localparam logic [31:0] C_RRDY  = 32'h4A4A957C;
    localparam logic [31:0] C_RIP   = 32'h5555B57C;
    localparam logic [31:0] C_ROK   = 32'h3535B57C;
    localparam logic [31:0] C_RERR  = 32'h5656B57C;
    localparam logic [31:0] C_XRDY  = 32'h5757B57C;
    localparam logic [31:0] C_WTRM  = 32'h5858B57C;
    localparam logic [31:0] C_HOLD  = 32'hD5D5AA7C;
    localparam logic [31:0] C_HOLDA = 32'h9595AA7C;
    localparam logic [31:0] C_SOF   = 32'h3737B57C;
    localparam logic [31:0] C_EOF   = 32'hD5D5B57C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        suppress_en = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_dword = '0;
    logic        in_is_prim = 1'b0;
    logic [31:0] out_dword;
    logic        out_k;

    always #4 clk = ~clk;

    tx_prim_conditioner #(.ALIGN_PERIOD(P)) u_tx_prim_conditioner (
        .clk         (clk),
        .rst         (rst),
        .suppress_en (suppress_en),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_dword    (in_dword),
        .in_is_prim  (in_is_prim),
        .out_dword   (out_dword),
        .out_k       (out_k)
    );

    typedef struct {
        logic [31:0] dw;
        bit          p;
    } item_t;

    typedef struct {
        int          kind;   // 0 real, 1 CONT, 2 filler
        logic [31:0] dw;
        bit          k;
        string       tag;
    } exp_t;

    item_t src[$];
    exp_t  expq[$];
    int    checks = 0;
    int    fails  = 0;
    bit [15:0] ms;
    int    oc;

    function automatic bit [15:0] m_next(input bit [15:0] s);
        bit [15:0] t = s;
        for (int i = 0; i < 32; i++) begin
            bit x = t[0];
            t = t >> 1;
            if (x) t = t ^ 16'h8805;
        end
        return t;
    endfunction

    function automatic bit [31:0] m_bits(input bit [15:0] s);
        bit [15:0] t = s;
        bit [31:0] r;
        for (int i = 0; i < 32; i++) begin
            bit x = t[0];
            r[i] = x;
            t = t >> 1;
            if (x) t = t ^ 16'h8805;
        end
        return r;
    endfunction

    function automatic bit m_rep(input item_t it);
        return it.p && (it.dw == C_SYNC || it.dw == C_RRDY || it.dw == C_RIP ||
                        it.dw == C_ROK || it.dw == C_RERR || it.dw == C_XRDY ||
                        it.dw == C_WTRM || it.dw == C_HOLD || it.dw == C_HOLDA);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual k,dword=%h expected k,dword=%h", tag, what, act, exp);
        end
    endtask

    task automatic add(input logic [31:0] dw, input bit p, input int n);
        for (int i = 0; i < n; i++) src.push_back('{dw: dw, p: p});
    endtask

    task automatic fill_stream();
        src.delete();
        add(C_SYNC, 1, 40);                    // long run crossing ALIGN pairs (R9)
        add(C_XRDY, 1, 3);
        add(C_SOF, 1, 1);
        for (int i = 0; i < 6; i++) add(32'h1357_0000 + i * 32'h0101_0101, 0, 1);
        add(C_SYNC, 0, 2);                     // data equal to SYNC pattern
        add(C_ALIGN, 0, 1);                    // data equal to ALIGN pattern
        add(C_HOLD, 1, 5);
        add(32'hCAFE_0001, 0, 2);
        add(C_HOLDA, 1, 2);
        add(32'hCAFE_0002, 0, 1);
        add(C_HOLDA, 1, 4);
        add(C_EOF, 1, 1);
        add(C_WTRM, 1, 6);
        add(C_ROK, 1, 1);
        add(C_RERR, 1, 4);
        add(C_SOF, 1, 4);                      // non-repeatable run
        add(C_SYNC, 1, 2);
        add(32'h0BAD_F00D, 0, 5);              // repeated data
        add(C_RIP, 1, 7);
        add(C_RRDY, 1, 4);
        add(C_SYNC, 1, 60);
        add(32'hDEAD_0000, 0, 1);              // sentinel, never emitted
    endtask

    task automatic build_exp(input bit en);
        int occ = 0;
        expq.delete();
        for (int i = 0; i < src.size() - 1; i++) begin
            bit same_prev = (i > 0) && (src[i-1].dw == src[i].dw) && (src[i-1].p == src[i].p);
            bit fin = !((src[i+1].dw == src[i].dw) && (src[i+1].p == src[i].p));
            bit rep = m_rep(src[i]);
            occ = (rep && same_prev) ? occ + 1 : 1;
            if (en && rep && !fin && occ == 3)
                expq.push_back('{kind: 1, dw: C_CONT, k: 1, tag: "R6"});
            else if (en && rep && !fin && occ >= 4)
                expq.push_back('{kind: 2, dw: '0, k: 0, tag: "R8 R9"});
            else if (!en)
                expq.push_back('{kind: 0, dw: src[i].dw, k: src[i].p, tag: "R10"});
            else if (rep)
                expq.push_back('{kind: 0, dw: src[i].dw, k: src[i].p, tag: "R7"});
            else
                expq.push_back('{kind: 0, dw: src[i].dw, k: src[i].p, tag: "R5 R4"});
        end
    endtask

    task automatic present();
        if (src.size() > 0) begin
            in_valid   = 1'b1;
            in_dword   = src[0].dw;
            in_is_prim = src[0].p;
        end else begin
            in_valid   = 1'b0;
            in_dword   = '0;
            in_is_prim = 1'b0;
        end
    endtask

    task automatic monitor();
        bit is_al = out_k && (out_dword == C_ALIGN);
        if (oc % P < 2) begin
            check(is_al, (oc < 2) ? "R1" : "R2", "ALIGN slot",
                  {out_k, out_dword}, {1'b1, C_ALIGN});
        end else if (is_al) begin
            check(!in_valid, "R3", "ALIGN while dword available",
                  {out_k, out_dword}, {1'b0, 32'h0});
            if (!in_valid) check(1'b1, "R11", "idle fill", {out_k, out_dword}, {1'b1, C_ALIGN});
        end else if (expq.size() == 0) begin
            check(1'b0, "R11", "dword with nothing pending",
                  {out_k, out_dword}, {1'b1, C_ALIGN});
        end else begin
            exp_t e = expq.pop_front();
            logic [31:0] ev = (e.kind == 2) ? m_bits(ms) : e.dw;
            check(out_k == e.k && out_dword == ev, e.tag, "stream dword",
                  {out_k, out_dword}, {e.k, ev});
        end
    endtask

    task automatic run_phase(input bit en);
        int guard = 0;
        int tail = 0;
        rst = 1'b1;
        in_valid = 1'b0;
        suppress_en = en;
        fill_stream();
        build_exp(en);
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        ms = 16'hFFFF;
        oc = 0;
        present();
        while (tail < 2 * P && guard < 20000) begin
            bit fire;
            @(negedge clk);
            monitor();
            fire = in_valid && in_ready;
            @(posedge clk);
            #2;
            if (fire) void'(src.pop_front());
            present();
            ms = m_next(ms);
            oc++;
            guard++;
            if (src.size() == 0 && expq.size() == 0) tail++;
        end
        check(expq.size() == 0, "R3", "all dwords emitted",
              33'(expq.size()), 33'(0));
    endtask

    initial begin
        run_phase(1'b1);
        run_phase(1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule